// File: doc/BRIEF.md
# Packet CRC Inserter and Checker

This block sits on a byte-wide packet stream and protects each packet with a 16-bit CRC. The stream marks the first byte of a packet with a start flag and the last byte with an end flag. In insert mode, the block forwards every byte unchanged. After the last byte it appends the CRC, high byte first. When a packet carries more than a fixed number of bytes (80 by default), it also places an intermediate CRC right after that many bytes. The input is held off for two cycles while each CRC pair goes out.

In check mode, the block consumes a stream that already carries these CRCs. One cycle after each packet's last byte it reports a pass/fail verdict. The CRC starts from all ones, runs MSB first with the generator x^16 + x^12 + x^5 + 1, and has no final inversion. The intermediate CRC does not restart the running value, so the final CRC also covers the two intermediate bytes. The top bits of the first header byte carry a per-link tag that may be rewritten hop by hop. These bits count as zero in the CRC, so the checksum survives such rewrites.

Top module: `pkt_crc_guard`

## Requirements
- R1: In insert mode (CHECK_MODE=0), a byte accepted on a clock edge (in_valid and in_ready high) appears on out_data one cycle later with out_valid high. out_sop is high exactly when the byte was marked in_sop, and out_eop is low.
- R2: The CRC uses generator 0x1021 with seed 0xFFFF. It processes each byte MSB first, with no reflection and no final XOR.
- R3: After a packet's last byte, insert mode emits the final CRC as two beats, bits 15:8 and then bits 7:0. out_eop is high only on the second of these beats.
- R4: When a packet's 80th byte (index 79) is accepted without in_eop, the intermediate CRC over bytes 0 to 79 is emitted next as two beats (high byte, low byte), and the data stream then resumes. A packet of exactly 80 bytes gets only the final CRC.
- R5: The running CRC is not reset at the intermediate CRC. The final CRC covers all data bytes and both intermediate CRC bytes.
- R6: In insert mode, in_ready drops for exactly two cycles for each CRC pair, starting the cycle after the byte that triggers the pair. Otherwise it stays high.
- R7: The top 5 bits (7:3) of a packet's first byte are taken as zero for the CRC. Changing them changes neither emitted CRC nor a check verdict.
- R8: In check mode (CHECK_MODE=1), in_ready is always high and out_valid stays low. res_valid pulses for one cycle, one cycle after each byte carrying in_eop, and at no other time.
- R9: In check mode, a packet laid out as insert mode produces it (including the intermediate CRC at received byte indices 80 and 81) is reported with res_pass high.
- R10: In check mode, any corruption of data or final CRC bytes gives res_pass low.
- R11: In check mode, if the running CRC after received byte index 81 is nonzero, the packet fails, even when the final CRC is consistent with the received bytes.
- R12: In check mode, a packet shorter than 4 bytes fails whatever its content. A 4-byte packet with a valid CRC passes.
- R13: While reset is held and right after it, out_valid and res_valid are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Block accepts the input byte this cycle |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Input byte is the first of a packet |
| in_eop | input | 1 | Input byte is the last of a packet |
| out_valid | output | 1 | Output byte present (insert mode) |
| out_data | output | 8 | Output byte: data or inserted CRC |
| out_sop | output | 1 | Output byte is the first of a packet |
| out_eop | output | 1 | Output byte is the last of a packet (final CRC low byte) |
| res_valid | output | 1 | Verdict present (check mode) |
| res_pass | output | 1 | Verdict: both CRCs matched and length was sufficient |

## Verification
The assertions check the following on every cycle:
- the one-cycle forwarding of accepted bytes with their start flag;
- the exact two-cycle shape of every input stall;
- the position of the end flag right after a stall;
- the silent output side in check mode and the one-cycle timing of its verdict.

CRC values, the placement of the intermediate pair at the 80-byte boundary, the exactly-80-byte case, and independence from the tag bits can only be shown by the bench's packets compared against its reference stream. The same holds for pass and fail verdicts on clean, corrupted, resealed and short packets.

// File: rtl/pkt_crc_pkg.sv
package pkt_crc_pkg;

   // sequencer of the insert path: pass data, then high and low CRC beat
   typedef enum logic [1:0] {
      INS_PASS = 2'd0,
      INS_HI   = 2'd1,
      INS_LO   = 2'd2
   } ins_state_t;

   // block variants picked at elaboration
   typedef enum bit {
      MODE_INSERT = 1'b0,
      MODE_CHECK  = 1'b1
   } guard_mode_t;

endpackage

// File: rtl/pkt_crc_step.sv
// One byte of a non-reflected CRC, MSB first.
module pkt_crc_step #(
   parameter int CRC_W  = 16,
   parameter int DATA_W = 8,
   parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
   input  logic [CRC_W-1:0]  crc_in,
   input  logic [DATA_W-1:0] din,
   output logic [CRC_W-1:0]  crc_out
);

   always_comb begin
      crc_out = crc_in;
      for (int k = DATA_W - 1; k >= 0; k--) begin
         if (crc_out[CRC_W-1] ^ din[k]) begin
            crc_out = {crc_out[CRC_W-2:0], 1'b0} ^ POLY;
         end else begin
            crc_out = {crc_out[CRC_W-2:0], 1'b0};
         end
      end
   end

endmodule

// File: rtl/pkt_crc_insert.sv
// Transmit side: forwards bytes, inserts intermediate and final CRC pairs.
module pkt_crc_insert
   import pkt_crc_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int CRC_W     = 16,
   parameter logic [CRC_W-1:0] POLY = 16'h1021,
   parameter logic [CRC_W-1:0] SEED = 16'hFFFF,
   parameter int SPLIT_LEN = 80,
   parameter int TAG_BITS  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_sop,
   input  logic              in_eop,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_sop,
   output logic              out_eop
);

   localparam int CNT_W = $clog2(SPLIT_LEN + 1);
   localparam logic [CNT_W-1:0] SPLIT_LAST = CNT_W'(SPLIT_LEN - 1);
   localparam logic [CNT_W-1:0] SPLIT_SAT  = CNT_W'(SPLIT_LEN);
   localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'((1 << (DATA_W - TAG_BITS)) - 1);

   ins_state_t        state_q;
   logic [CRC_W-1:0]  crc_q;
   logic [DATA_W-1:0] lo_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              fin_q;

   logic              take;
   logic [CNT_W-1:0]  idx;
   logic [DATA_W-1:0] byte_in;
   logic [DATA_W-1:0] step_din;
   logic [CRC_W-1:0]  step_cin;
   logic [CRC_W-1:0]  step_out;

   assign in_ready = (state_q == INS_PASS);
   assign take     = in_valid && in_ready;
   assign idx      = in_sop ? '0 : cnt_q;
   assign byte_in  = in_sop ? (in_data & KEEP_MASK) : in_data;

   always_comb begin
      unique case (state_q)
         INS_HI:  step_din = crc_q[CRC_W-1 -: DATA_W];
         INS_LO:  step_din = lo_q;
         default: step_din = byte_in;
      endcase
      step_cin = ((state_q == INS_PASS) && in_sop) ? SEED : crc_q;
   end

   pkt_crc_step #(
      .CRC_W (CRC_W),
      .DATA_W(DATA_W),
      .POLY  (POLY)
   ) i_step (
      .crc_in (step_cin),
      .din    (step_din),
      .crc_out(step_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= INS_PASS;
         crc_q     <= SEED;
         lo_q      <= '0;
         cnt_q     <= '0;
         fin_q     <= 1'b0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_sop   <= 1'b0;
         out_eop   <= 1'b0;
      end else begin
         unique case (state_q)
            INS_PASS: begin
               out_valid <= take;
               out_sop   <= take && in_sop;
               out_eop   <= 1'b0;
               if (take) begin
                  out_data <= in_data;
                  crc_q    <= step_out;
                  cnt_q    <= (idx == SPLIT_SAT) ? idx : idx + 1'b1;
                  if (in_eop) begin
                     state_q <= INS_HI;
                     fin_q   <= 1'b1;
                  end else if (idx == SPLIT_LAST) begin
                     state_q <= INS_HI;
                     fin_q   <= 1'b0;
                  end
               end
            end
            INS_HI: begin
               out_valid <= 1'b1;
               out_sop   <= 1'b0;
               out_eop   <= 1'b0;
               out_data  <= crc_q[CRC_W-1 -: DATA_W];
               lo_q      <= crc_q[DATA_W-1:0];
               crc_q     <= step_out;
               state_q   <= INS_LO;
            end
            INS_LO: begin
               out_valid <= 1'b1;
               out_sop   <= 1'b0;
               out_eop   <= fin_q;
               out_data  <= lo_q;
               crc_q     <= step_out;
               state_q   <= INS_PASS;
            end
            default: state_q <= INS_PASS;
         endcase
      end
   end

endmodule

// File: rtl/pkt_crc_verify.sv
// Receive side: running residue must be zero after the intermediate pair and at the end.
module pkt_crc_verify #(
   parameter int DATA_W    = 8,
   parameter int CRC_W     = 16,
   parameter logic [CRC_W-1:0] POLY = 16'h1021,
   parameter logic [CRC_W-1:0] SEED = 16'hFFFF,
   parameter int SPLIT_LEN = 80,
   parameter int TAG_BITS  = 5,
   parameter int MIN_LEN   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_sop,
   input  logic              in_eop,
   output logic              res_valid,
   output logic              res_pass
);

   localparam int CNT_W = $clog2(SPLIT_LEN + MIN_LEN + 4);
   localparam logic [CNT_W-1:0] CNT_TOP   = '1;
   localparam logic [CNT_W-1:0] MID_CHECK = CNT_W'(SPLIT_LEN + 1);
   localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(MIN_LEN - 1);
   localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'((1 << (DATA_W - TAG_BITS)) - 1);

   logic [CRC_W-1:0]  crc_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              bad_q;

   logic [CNT_W-1:0]  idx;
   logic [DATA_W-1:0] byte_in;
   logic [CRC_W-1:0]  crc_cin;
   logic [CRC_W-1:0]  crc_nx;
   logic              mid_bad;
   logic              bad_nx;
   logic              short_pkt;

   assign idx       = in_sop ? '0 : cnt_q;
   assign byte_in   = in_sop ? (in_data & KEEP_MASK) : in_data;
   assign crc_cin   = in_sop ? SEED : crc_q;
   assign mid_bad   = (idx == MID_CHECK) && (crc_nx != '0);
   assign bad_nx    = (in_sop ? 1'b0 : bad_q) | mid_bad;
   assign short_pkt = (idx < SHORT_LIM);

   pkt_crc_step #(
      .CRC_W (CRC_W),
      .DATA_W(DATA_W),
      .POLY  (POLY)
   ) i_step (
      .crc_in (crc_cin),
      .din    (byte_in),
      .crc_out(crc_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         crc_q     <= SEED;
         cnt_q     <= '0;
         bad_q     <= 1'b0;
         res_valid <= 1'b0;
         res_pass  <= 1'b0;
      end else begin
         res_valid <= in_valid && in_eop;
         if (in_valid) begin
            crc_q <= crc_nx;
            cnt_q <= (idx == CNT_TOP) ? idx : idx + 1'b1;
            bad_q <= bad_nx;
            if (in_eop) begin
               res_pass <= !bad_nx && (crc_nx == '0) && !short_pkt;
            end
         end
      end
   end

endmodule

// File: rtl/pkt_crc_guard.sv
// Top: selects the insert or the check variant at elaboration.
module pkt_crc_guard
   import pkt_crc_pkg::*;
#(
   parameter bit CHECK_MODE = 1'b0,
   parameter int DATA_W     = 8,
   parameter int CRC_W      = 16,
   parameter logic [CRC_W-1:0] POLY = 16'h1021,
   parameter logic [CRC_W-1:0] SEED = 16'hFFFF,
   parameter int SPLIT_LEN  = 80,
   parameter int TAG_BITS   = 5,
   parameter int MIN_LEN    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_sop,
   input  logic              in_eop,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_sop,
   output logic              out_eop,
   output logic              res_valid,
   output logic              res_pass
);

   localparam guard_mode_t MODE = guard_mode_t'(CHECK_MODE);

   // parameter sanity, resolved at elaboration
   if (CRC_W != 2 * DATA_W) begin : g_bad_width
      $error("CRC width must be two data bytes");
   end
   if (TAG_BITS < 0 || TAG_BITS >= DATA_W) begin : g_bad_tag
      $error("tag field must fit inside the first byte");
   end
   if (SPLIT_LEN < 2) begin : g_bad_split
      $error("intermediate boundary too small");
   end
   if (MIN_LEN < 3) begin : g_bad_min
      $error("minimum length must exceed the CRC pair");
   end

   if (MODE == MODE_INSERT) begin : g_insert
      pkt_crc_insert #(
         .DATA_W   (DATA_W),
         .CRC_W    (CRC_W),
         .POLY     (POLY),
         .SEED     (SEED),
         .SPLIT_LEN(SPLIT_LEN),
         .TAG_BITS (TAG_BITS)
      ) i_insert (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_valid (in_valid),
         .in_ready (in_ready),
         .in_data  (in_data),
         .in_sop   (in_sop),
         .in_eop   (in_eop),
         .out_valid(out_valid),
         .out_data (out_data),
         .out_sop  (out_sop),
         .out_eop  (out_eop)
      );
      assign res_valid = 1'b0;
      assign res_pass  = 1'b0;
   end else begin : g_check
      pkt_crc_verify #(
         .DATA_W   (DATA_W),
         .CRC_W    (CRC_W),
         .POLY     (POLY),
         .SEED     (SEED),
         .SPLIT_LEN(SPLIT_LEN),
         .TAG_BITS (TAG_BITS),
         .MIN_LEN  (MIN_LEN)
      ) i_verify (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_valid (in_valid),
         .in_data  (in_data),
         .in_sop   (in_sop),
         .in_eop   (in_eop),
         .res_valid(res_valid),
         .res_pass (res_pass)
      );
      assign in_ready  = 1'b1;
      assign out_valid = 1'b0;
      assign out_data  = '0;
      assign out_sop   = 1'b0;
      assign out_eop   = 1'b0;
   end

endmodule

// File: rtl/pkt_crc_guard_chk.sv
// Protocol checks on the ports of pkt_crc_guard.
module pkt_crc_guard_chk #(
   parameter bit CHECK_MODE = 1'b0,
   parameter int DATA_W     = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [DATA_W-1:0] in_data,
   input logic              in_sop,
   input logic              in_eop,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic              out_sop,
   input logic              out_eop,
   input logic              res_valid,
   input logic              res_pass
);

   if (!CHECK_MODE) begin : g_tx
      a_r1_forward: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)
                                     && out_sop == $past(in_sop) && !out_eop));
      a_r6_stall_after_end: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_ready && in_eop) |=> !in_ready);
      a_r6_stall_two: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(in_ready) |=> !in_ready);
      a_r6_stall_ends: assert property (@(posedge clk) disable iff (!rst_n)
         (!in_ready && !$past(in_ready)) |=> in_ready);
      a_r3_eop_tail: assert property (@(posedge clk) disable iff (!rst_n)
         out_eop |-> (out_valid && in_ready && !$past(in_ready)));
      a_r8_tx_no_verdict: assert property (@(posedge clk) disable iff (!rst_n)
         !res_valid && !res_pass);
   end else begin : g_rx
      a_r8_rx_ready: assert property (@(posedge clk) disable iff (!rst_n)
         in_ready && !out_valid && !out_sop && !out_eop && out_data == '0);
      a_r8_verdict_cause: assert property (@(posedge clk) disable iff (!rst_n)
         res_valid |-> $past(in_valid && in_eop));
      a_r8_verdict_due: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_eop) |=> res_valid);
      a_r12_single_byte: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && in_sop && in_eop && in_data != '1) |=> !res_pass);
   end

endmodule

bind pkt_crc_guard pkt_crc_guard_chk #(
   .CHECK_MODE(CHECK_MODE),
   .DATA_W    (DATA_W)
) i_guard_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_ready (in_ready),
   .in_data  (in_data),
   .in_sop   (in_sop),
   .in_eop   (in_eop),
   .out_valid(out_valid),
   .out_data (out_data),
   .out_sop  (out_sop),
   .out_eop  (out_eop),
   .res_valid(res_valid),
   .res_pass (res_pass)
);

// File: tb/test_pkt_crc_guard.sv
module test_pkt_crc_guard;

   localparam int CLK_PERIOD = 10;
   localparam int SPLIT      = 80;

   typedef logic [7:0] bq_t[$];

   logic clk = 1'b0;
   logic rst_n = 1'b0;

   // insert-mode instance signals
   logic       tx_valid = 1'b0, tx_sop = 1'b0, tx_eop = 1'b0;
   logic [7:0] tx_data = '0;
   logic       tx_ready, txo_valid, txo_sop, txo_eop, tx_rv, tx_rp;
   logic [7:0] txo_data;

   // check-mode instance signals
   logic       rx_valid = 1'b0, rx_sop = 1'b0, rx_eop = 1'b0;
   logic [7:0] rx_data = '0;
   logic       rx_ready, rxo_valid, rxo_sop, rxo_eop, rx_rv, rx_rp;
   logic [7:0] rxo_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   int first_stall = 0;

   logic [9:0] exp_beat[$];
   string      exp_req[$];
   logic [7:0] prev_d = '0;
   logic [15:0] last_fin = '0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pkt_crc_guard #(.CHECK_MODE(1'b0)) i_pkt_crc_guard (
      .clk(clk), .rst_n(rst_n),
      .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_data),
      .in_sop(tx_sop), .in_eop(tx_eop),
      .out_valid(txo_valid), .out_data(txo_data), .out_sop(txo_sop), .out_eop(txo_eop),
      .res_valid(tx_rv), .res_pass(tx_rp)
   );

   pkt_crc_guard #(.CHECK_MODE(1'b1)) i_pkt_crc_guard_rx (
      .clk(clk), .rst_n(rst_n),
      .in_valid(rx_valid), .in_ready(rx_ready), .in_data(rx_data),
      .in_sop(rx_sop), .in_eop(rx_eop),
      .out_valid(rxo_valid), .out_data(rxo_data), .out_sop(rxo_sop), .out_eop(rxo_eop),
      .res_valid(rx_rv), .res_pass(rx_rp)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] got,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   // reference CRC: generator 0x1021, MSB first
   function automatic logic [15:0] ref_step(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r;
      r = c;
      for (int b = 7; b >= 0; b--) begin
         logic fb;
         fb = r[15] ^ d[b];
         r = r << 1;
         if (fb) r = r ^ 16'h1021;
      end
      return r;
   endfunction

   function automatic logic [7:0] masked(input int i, input logic [7:0] d);
      return (i == 0) ? (d & 8'h07) : d;
   endfunction

   function automatic bq_t mk(input int n, input int seed);
      bq_t p;
      for (int i = 0; i < n; i++) p.push_back(8'((seed * 37 + i * 13 + i * i) & 255));
      return p;
   endfunction

   // expected wire image of a packet
   function automatic bq_t encode(input bq_t p);
      bq_t e;
      logic [15:0] c;
      c = 16'hFFFF;
      for (int i = 0; i < p.size(); i++) begin
         c = ref_step(c, masked(i, p[i]));
         e.push_back(p[i]);
         if (i == SPLIT - 1 && p.size() > SPLIT) begin
            logic [7:0] h, l;
            h = c[15:8];
            l = c[7:0];
            e.push_back(h);
            e.push_back(l);
            c = ref_step(ref_step(c, h), l);
         end
      end
      e.push_back(c[15:8]);
      e.push_back(c[7:0]);
      return e;
   endfunction

   // recompute the last two bytes over all preceding bytes
   function automatic bq_t reseal(input bq_t e);
      bq_t r;
      logic [15:0] c;
      r = e;
      c = 16'hFFFF;
      for (int i = 0; i < r.size() - 2; i++) c = ref_step(c, masked(i, r[i]));
      r[r.size() - 2] = c[15:8];
      r[r.size() - 1] = c[7:0];
      return r;
   endfunction

   // cycle monitor of the insert-mode output against the reference stream
   always @(negedge clk) begin
      if (rst_n && !done && txo_valid) begin
         if (exp_beat.size() == 0) begin
            check(1'b0, "R1 stray beat", {22'b0, txo_sop, txo_eop, txo_data}, 32'h0);
         end else begin
            logic [9:0] eb;
            string rq;
            eb = exp_beat.pop_front();
            rq = exp_req.pop_front();
            check({txo_sop, txo_eop, txo_data} == eb, rq,
                  {22'b0, txo_sop, txo_eop, txo_data}, {22'b0, eb});
         end
         if (txo_eop) last_fin = {prev_d, txo_data};
         prev_d = txo_data;
      end
   end

   task automatic send_tx(input bq_t p);
      bq_t e;
      int n;
      bit long_pkt;
      e = encode(p);
      n = p.size();
      long_pkt = (n > SPLIT);
      for (int k = 0; k < e.size(); k++) begin
         string rq;
         logic is_eop;
         is_eop = (k == e.size() - 1);
         if (k >= e.size() - 2) rq = long_pkt ? "R5 final crc" : "R2 R3 final crc";
         else if (long_pkt && (k == SPLIT || k == SPLIT + 1)) rq = "R4 mid crc";
         else rq = "R1 data";
         exp_beat.push_back({(k == 0), is_eop, e[k]});
         exp_req.push_back(rq);
      end
      for (int i = 0; i < n; i++) begin
         int stalls;
         int exp_st;
         @(negedge clk);
         tx_valid = 1'b1;
         tx_data  = p[i];
         tx_sop   = (i == 0);
         tx_eop   = (i == n - 1);
         stalls = 0;
         while (!tx_ready) begin
            stalls++;
            @(negedge clk);
         end
         exp_st = (i == SPLIT) ? 2 : ((i == 0) ? first_stall : 0);
         check(stalls == exp_st, "R6 stall", stalls, exp_st);
      end
      first_stall = 2;
   endtask

   task automatic idle_tx(input int n);
      @(negedge clk);
      tx_valid = 1'b0;
      tx_sop   = 1'b0;
      tx_eop   = 1'b0;
      repeat (n - 1) @(negedge clk);
      if (n >= 3) first_stall = 0;
   endtask

   task automatic drain_tx();
      while (exp_beat.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic send_rx(input bq_t e, input bit exp_pass, input string rq);
      for (int i = 0; i < e.size(); i++) begin
         bit last;
         last = (i == e.size() - 1);
         @(negedge clk);
         rx_valid = 1'b1;
         rx_data  = e[i];
         rx_sop   = (i == 0);
         rx_eop   = last;
         @(posedge clk);
         #1;
         check(rx_ready && !rxo_valid, "R8 ready/quiet", {rx_ready, rxo_valid}, 2'b10);
         check(rx_rv == last, "R8 verdict timing", rx_rv, last);
         if (last) check(rx_rp == exp_pass, rq, rx_rp, exp_pass);
      end
      @(negedge clk);
      rx_valid = 1'b0;
      rx_sop   = 1'b0;
      rx_eop   = 1'b0;
   endtask

   task automatic report();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL R1 watchdog: got hang expected completion");
         report();
         $finish;
      end
   end

   initial begin
      bq_t p, q, e;
      logic [15:0] fin_a;

      // R13: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(!txo_valid && tx_ready && !tx_rv, "R13 tx in reset",
            {txo_valid, tx_ready, tx_rv}, 3'b010);
      check(!rx_rv && rx_ready, "R13 rx in reset", {rx_rv, rx_ready}, 2'b01);
      rst_n = 1'b1;
      @(negedge clk);
      check(!txo_valid && tx_ready && !rx_rv, "R13 after reset",
            {txo_valid, tx_ready, rx_rv}, 3'b010);

      // insert mode: short, single byte, back to back
      send_tx(mk(10, 1));
      send_tx(mk(1, 2));
      send_tx(mk(6, 3));
      idle_tx(4);
      drain_tx();

      // R4 boundary: exactly 80 bytes, then 81, then long
      send_tx(mk(80, 4));
      idle_tx(4);
      drain_tx();
      send_tx(mk(81, 5));
      idle_tx(4);
      drain_tx();
      send_tx(mk(200, 6));
      send_tx(mk(3, 7));
      idle_tx(4);
      drain_tx();

      // R7: tag bits do not change the emitted CRC
      p = mk(12, 8);
      q = p;
      q[0] = p[0] ^ 8'hF8;
      send_tx(p);
      idle_tx(4);
      drain_tx();
      fin_a = last_fin;
      send_tx(q);
      idle_tx(4);
      drain_tx();
      check(last_fin == fin_a, "R7 tag ignored", last_fin, fin_a);
      check(exp_beat.size() == 0, "R1 all beats seen", exp_beat.size(), 0);

      // check mode
      send_rx(encode(mk(10, 11)), 1'b1, "R9 clean short");
      send_rx(encode(mk(100, 12)), 1'b1, "R9 clean long");
      send_rx(encode(mk(80, 13)), 1'b1, "R9 exactly 80");
      e = encode(mk(10, 14));
      e[4] = e[4] ^ 8'h10;
      send_rx(e, 1'b0, "R10 data corrupt");
      e = encode(mk(10, 15));
      e[e.size() - 1] = e[e.size() - 1] ^ 8'h01;
      send_rx(e, 1'b0, "R10 crc corrupt");
      e = encode(mk(120, 16));
      e[SPLIT] = e[SPLIT] ^ 8'h40;
      e = reseal(e);
      send_rx(e, 1'b0, "R11 mid crc corrupt");
      e = encode(mk(20, 17));
      e[0] = e[0] ^ 8'hA8;
      send_rx(e, 1'b1, "R7 tag ignored rx");
      send_rx(reseal(mk(3, 18)), 1'b0, "R12 three bytes");
      send_rx(mk(1, 19), 1'b0, "R12 one byte");
      send_rx(reseal(mk(4, 20)), 1'b1, "R12 four bytes");

      repeat (3) @(negedge clk);
      done = 1'b1;
      report();
      $finish;
   end

endmodule